// File: doc/BRIEF.md
# Serial Real-Time-Clock Command Slave

This block is the clock chip behind three bits of a host control register: a select line, a serial clock and a serial data line. The host opens a frame by raising select. It then produces falling clock edges. The first eight edges carry a command byte and the next eight carry a value byte, each sent most significant bit first. The command byte picks the register that the frame addresses. Read commands send a byte back during the value half of the frame. The block presents that returned bit as a registered output, so the host can read it back through its control register.

Behind the frame logic there are three kinds of state. The first is a small battery-backed RAM that loads a computed preset image at reset. The second is a status byte whose fault bits the host can clear with a dedicated command. When it does, the block sends a one-cycle request that clears a matching bit in the system interrupt status. The third is a time-of-day counter that advances on a one-second tick input and can be loaded from a preset. Its fields are read back as two-digit BCD.

Top module: `rtc_serial_slave`

## Requirements
- R1: A bit is taken from `sdat_i` only in a cycle where `sclk_i` is low, the registered previous `sclk_i` is high and `sel_i` is high. Rising edges, steady levels, data toggles and any edges while `sel_i` is low shift nothing.
- R2: The first 8 accepted edges of a frame shift the command in MSB first. Edges 9 to 16 shift the value byte in MSB first.
- R3: For commands 0x00 to 0x1F, each of the 8 value-phase edges sets `rdata_o` to the next bit of RAM byte [command], MSB first. `rdata_o` is valid from the cycle after that edge.
- R4: Command 0x30 returns the status byte and command 0x31 returns the control byte (fixed at 0x00), MSB first in the same way.
- R5: Commands 0x20, 0x21, 0x22, 0x24, 0x25 and 0x26 return BCD seconds, minutes, hours, day of month, month (1 to 12) and two-digit year. Every other code in 0x20 to 0x2F returns 0x00. So does any command outside the read ranges of R3 to R5.
- R6: On the 16th edge, a command in 0x80 to 0x9F writes the received value into RAM byte (command - 0x80).
- R7: On the 16th edge, command 0xB1 with value bit 2 set clears status bits 0x18 and raises `irq_clr_o` for exactly one cycle. With bit 2 clear, nothing changes. Status bits are never set by a frame.
- R8: A low `sel_i` aborts the frame. The edge count and the command and value registers return to zero, a partial frame commits nothing, and `rdata_o` is driven low.
- R9: After reset the status byte is 0x90 and `rdata_o` and `irq_clr_o` are low. RAM byte i holds ((29*i) mod 256) XOR 0x5A.
- R10: After 16 edges, later edges in the same selection neither shift nor commit until `sel_i` falls and rises again.
- R11: A `tick_i` pulse adds one second, with carries 59 s to 0, 59 min to 0, 23 h to 0, day 31 to 1, month 12 to 1 and year 99 to 0. `load_i` loads all the preset fields at once. The reset time is 00:00:00, day 1, month 1, year 0.
- R12: A read byte is captured at the first value-phase edge, so a tick later in the same frame does not mix two time values into the returned byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_i | input | 1 | Frame select from the host control register |
| sclk_i | input | 1 | Serial clock bit; bits are taken on its falling edge |
| sdat_i | input | 1 | Serial data bit from the host |
| rdata_o | output | 1 | Registered bit returned during the value phase |
| irq_clr_o | output | 1 | One-cycle request to clear the fault interrupt bit |
| tick_i | input | 1 | One-second advance pulse |
| load_i | input | 1 | Load the time counters from the preset fields |
| preset_sec_i | input | 6 | Preset seconds, 0 to 59 |
| preset_min_i | input | 6 | Preset minutes, 0 to 59 |
| preset_hour_i | input | 5 | Preset hours, 0 to 23 |
| preset_day_i | input | 5 | Preset day of month, 1 to 31 |
| preset_mon_i | input | 4 | Preset month, 1 to 12 |
| preset_year_i | input | 7 | Preset year, 0 to 99 |

## Verification
The hardest state to reach from the ports is a frame that keeps select high past its sixteenth edge. The bench shifts a second full write frame into the same selection and then shows that the RAM byte holds the first value. A tick that lands in the middle of a time read is also hard to reach. The bench pulses `tick_i` between value-phase edges and expects the byte that was captured at the first data edge. Aborted frames and noisy data between clock edges round out the edge and abort cases.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam logic [7:0] CMD_TIME_HI   = 8'h2;
    localparam logic [7:0] CMD_STATUS    = 8'h30;
    localparam logic [7:0] CMD_CONTROL   = 8'h31;
    localparam logic [7:0] CMD_WR_BASE   = 8'h80;
    localparam logic [7:0] CMD_FLAGCLR   = 8'hB1;
    localparam logic [7:0] FLAGCLR_KEY   = 8'h04;
    localparam logic [7:0] STATUS_RST    = 8'h90;
    localparam logic [7:0] STATUS_FAULTS = 8'h18;

    typedef struct packed {
        logic [5:0] sec;
        logic [5:0] min;
        logic [4:0] hour;
        logic [4:0] day;
        logic [3:0] mon;
        logic [6:0] year;
    } rtc_time_t;

    // Two decimal digits packed as tens:ones nibbles (input 0..99).
    function automatic logic [7:0] to_bcd(input logic [6:0] bin);
        logic [7:0] b;
        b = {1'b0, bin};
        return ((b / 8'd10) << 4) | (b % 8'd10);
    endfunction

    // Computed power-up image of the battery RAM.
    function automatic logic [7:0] ram_image(input int idx, input int mul,
                                             input logic [7:0] mask);
        return 8'(idx * mul) ^ mask;
    endfunction

endpackage

// File: rtl/rtc_frame_rx.sv
module rtc_frame_rx #(
    parameter int CMD_W = 8,
    parameter int VAL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_i,
    input  logic             sclk_i,
    input  logic             sdat_i,
    output logic             first_data_o,
    output logic             data_edge_o,
    output logic             commit_o,
    output logic [CMD_W-1:0] cmd_o,
    output logic [VAL_W-1:0] commit_val_o
);
    localparam int FRAME_LEN = CMD_W + VAL_W;
    localparam int PH_W      = $clog2(FRAME_LEN + 1);
    localparam logic [PH_W-1:0] PH_CMD  = PH_W'(CMD_W);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(FRAME_LEN - 1);
    localparam logic [PH_W-1:0] PH_END  = PH_W'(FRAME_LEN);

    typedef struct packed {
        logic             sclk;
        logic [PH_W-1:0]  phase;
        logic [CMD_W-1:0] cmd;
        logic [VAL_W-1:0] val;
    } rx_state_t;

    rx_state_t s_q, s_d;
    logic      fall;

    always_comb begin
        fall = sel_i && s_q.sclk && !sclk_i && (s_q.phase < PH_END);
        s_d      = s_q;
        s_d.sclk = sclk_i;
        if (!sel_i) begin
            s_d.phase = '0;
            s_d.cmd   = '0;
            s_d.val   = '0;
        end else if (fall) begin
            s_d.phase = s_q.phase + 1'b1;
            if (s_q.phase < PH_CMD)
                s_d.cmd = {s_q.cmd[CMD_W-2:0], sdat_i};
            else
                s_d.val = {s_q.val[VAL_W-2:0], sdat_i};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign first_data_o = fall && (s_q.phase == PH_CMD);
    assign data_edge_o  = fall && (s_q.phase >= PH_CMD);
    assign commit_o     = fall && (s_q.phase == PH_LAST);
    assign cmd_o        = s_q.cmd;
    assign commit_val_o = {s_q.val[VAL_W-2:0], sdat_i};

endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
    import rtc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick_i,
    input  logic      load_i,
    input  rtc_time_t preset_i,
    output rtc_time_t now_o
);
    localparam rtc_time_t TIME_RST = '{sec: 6'd0, min: 6'd0, hour: 5'd0,
                                       day: 5'd1, mon: 4'd1, year: 7'd0};

    rtc_time_t t_q, t_d;

    always_comb begin
        t_d = t_q;
        if (load_i) begin
            t_d = preset_i;
        end else if (tick_i) begin
            if (t_q.sec != 6'd59) t_d.sec = t_q.sec + 6'd1;
            else begin
                t_d.sec = 6'd0;
                if (t_q.min != 6'd59) t_d.min = t_q.min + 6'd1;
                else begin
                    t_d.min = 6'd0;
                    if (t_q.hour != 5'd23) t_d.hour = t_q.hour + 5'd1;
                    else begin
                        t_d.hour = 5'd0;
                        if (t_q.day != 5'd31) t_d.day = t_q.day + 5'd1;
                        else begin
                            t_d.day = 5'd1;
                            if (t_q.mon != 4'd12) t_d.mon = t_q.mon + 4'd1;
                            else begin
                                t_d.mon  = 4'd1;
                                t_d.year = (t_q.year == 7'd99) ? 7'd0 : t_q.year + 7'd1;
                            end
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= TIME_RST;
        else        t_q <= t_d;
    end

    assign now_o = t_q;

endmodule

// File: rtl/rtc_serial_slave.sv
module rtc_serial_slave
    import rtc_pkg::*;
#(
    parameter int         RAM_WORDS  = 32,
    parameter int         PRESET_MUL = 29,
    parameter logic [7:0] PRESET_XOR = 8'h5A,
    parameter logic [7:0] CTRL_VALUE = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel_i,
    input  logic       sclk_i,
    input  logic       sdat_i,
    output logic       rdata_o,
    output logic       irq_clr_o,
    input  logic       tick_i,
    input  logic       load_i,
    input  logic [5:0] preset_sec_i,
    input  logic [5:0] preset_min_i,
    input  logic [4:0] preset_hour_i,
    input  logic [4:0] preset_day_i,
    input  logic [3:0] preset_mon_i,
    input  logic [6:0] preset_year_i
);
    localparam int         AW       = $clog2(RAM_WORDS);
    localparam logic [7:0] RD_LIMIT = 8'(RAM_WORDS);
    localparam logic [7:0] WR_LIMIT = CMD_WR_BASE + RD_LIMIT;

    typedef struct packed {
        logic [RAM_WORDS-1:0][7:0] ram;
        logic [7:0]                status;
        logic [7:0]                rd_sh;
        logic                      rdata;
        logic                      irq;
    } slave_state_t;

    function automatic slave_state_t reset_state();
        slave_state_t r;
        r        = '0;
        r.status = STATUS_RST;
        for (int i = 0; i < RAM_WORDS; i++)
            r.ram[i] = ram_image(i, PRESET_MUL, PRESET_XOR);
        return r;
    endfunction

    slave_state_t s_q, s_d;
    logic         first_data, data_edge, commit;
    logic [7:0]   cmd, commit_val, rd_byte, time_byte;
    rtc_time_t    preset, now;

    assign preset = '{sec: preset_sec_i, min: preset_min_i, hour: preset_hour_i,
                      day: preset_day_i, mon: preset_mon_i, year: preset_year_i};

    rtc_frame_rx #(.CMD_W(8), .VAL_W(8)) u_rx (
        .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .sclk_i(sclk_i), .sdat_i(sdat_i),
        .first_data_o(first_data), .data_edge_o(data_edge), .commit_o(commit),
        .cmd_o(cmd), .commit_val_o(commit_val)
    );

    rtc_timekeeper u_time (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .load_i(load_i),
        .preset_i(preset), .now_o(now)
    );

    always_comb begin
        case (cmd[3:0])
            4'h0:    time_byte = to_bcd({1'b0, now.sec});
            4'h1:    time_byte = to_bcd({1'b0, now.min});
            4'h2:    time_byte = to_bcd({2'b0, now.hour});
            4'h4:    time_byte = to_bcd({2'b0, now.day});
            4'h5:    time_byte = to_bcd({3'b0, now.mon});
            4'h6:    time_byte = to_bcd(now.year);
            default: time_byte = 8'h00;
        endcase
        if (cmd < RD_LIMIT)                rd_byte = s_q.ram[cmd[AW-1:0]];
        else if (cmd == CMD_STATUS)        rd_byte = s_q.status;
        else if (cmd == CMD_CONTROL)       rd_byte = CTRL_VALUE;
        else if (cmd[7:4] == CMD_TIME_HI[3:0]) rd_byte = time_byte;
        else                               rd_byte = 8'h00;
    end

    always_comb begin
        s_d     = s_q;
        s_d.irq = 1'b0;
        if (!sel_i) begin
            s_d.rdata = 1'b0;
            s_d.rd_sh = '0;
        end else if (first_data) begin
            s_d.rdata = rd_byte[7];
            s_d.rd_sh = {rd_byte[6:0], 1'b0};
        end else if (data_edge) begin
            s_d.rdata = s_q.rd_sh[7];
            s_d.rd_sh = {s_q.rd_sh[6:0], 1'b0};
        end
        if (commit) begin
            if (cmd >= CMD_WR_BASE && cmd < WR_LIMIT)
                s_d.ram[cmd[AW-1:0]] = commit_val;
            if (cmd == CMD_FLAGCLR && (commit_val & FLAGCLR_KEY) != 8'h00) begin
                s_d.status = s_q.status & ~STATUS_FAULTS;
                s_d.irq    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= reset_state();
        else        s_q <= s_d;
    end

    assign rdata_o   = s_q.rdata;
    assign irq_clr_o = s_q.irq;

endmodule

// File: rtl/rtc_serial_slave_chk.sv
module rtc_serial_slave_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sel_i,
    input logic       sclk_i,
    input logic       rdata_o,
    input logic       irq_clr_o,
    input logic [7:0] status_i
);
    // R7
    irq_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clr_o |=> !irq_clr_o);

    // R7
    irq_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clr_o |-> ($past(sel_i) && !$past(sclk_i)));

    // R7
    status_never_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_i & ~$past(status_i)) == 8'h00));

    // R8
    abort_drops_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_i |=> !rdata_o);

    // R1
    no_edge_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && sclk_i) |=> $stable(rdata_o));
endmodule

bind rtc_serial_slave rtc_serial_slave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .sclk_i(sclk_i),
    .rdata_o(rdata_o), .irq_clr_o(irq_clr_o), .status_i(s_q.status)
);

// File: tb/tb_rtc_serial_slave.sv
`timescale 1ns/1ps
module tb_rtc_serial_slave;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel = 1'b0, sclk = 1'b0, sdat = 1'b0;
    logic tick = 1'b0, load = 1'b0;
    logic [5:0] p_sec = '0, p_min = '0;
    logic [4:0] p_hour = '0, p_day = 5'd1;
    logic [3:0] p_mon = 4'd1;
    logic [6:0] p_year = '0;
    logic rdata, irq_clr;

    int total = 0, bad = 0, irq_cnt = 0;
    bit done = 0;
    logic [7:0] ram_model [32];
    logic [7:0] got;

    always #4 clk = ~clk;

    rtc_serial_slave dut (
        .clk(clk), .rst_n(rst_n), .sel_i(sel), .sclk_i(sclk), .sdat_i(sdat),
        .rdata_o(rdata), .irq_clr_o(irq_clr), .tick_i(tick), .load_i(load),
        .preset_sec_i(p_sec), .preset_min_i(p_min), .preset_hour_i(p_hour),
        .preset_day_i(p_day), .preset_mon_i(p_mon), .preset_year_i(p_year)
    );

    always @(posedge clk) if (rst_n && irq_clr) irq_cnt++;

    function automatic logic [7:0] bcd(input int x);
        return 8'(((x / 10) << 4) + (x % 10));
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic pulse_tick();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
    endtask

    task automatic preset(input int s, input int m, input int h, input int d,
                          input int mo, input int y);
        @(negedge clk);
        p_sec = 6'(s); p_min = 6'(m); p_hour = 5'(h);
        p_day = 5'(d); p_mon = 4'(mo); p_year = 7'(y); load = 1'b1;
        @(negedge clk) load = 1'b0;
    endtask

    // One bit: raise clock, lower it, optional data noise after the fall.
    task automatic send_bit(input logic b, input bit noisy);
        @(negedge clk) begin sdat = b; sclk = 1'b1; end
        @(negedge clk);
        @(negedge clk) sclk = 1'b0;
        @(negedge clk) if (noisy) sdat = ~sdat;
        @(negedge clk) if (noisy) sdat = ~sdat;
    endtask

    // 16 edges with select held; tick_at selects a bit index for a tick, -1 none.
    task automatic shift16(input logic [7:0] c, input logic [7:0] v, input bit noisy,
                           input int tick_at, output logic [7:0] r);
        r = '0;
        for (int i = 0; i < 8; i++) send_bit(c[7-i], noisy);
        for (int i = 0; i < 8; i++) begin
            send_bit(v[7-i], noisy);
            r = {r[6:0], rdata};
            if (i == tick_at) pulse_tick();
        end
    endtask

    task automatic frame(input logic [7:0] c, input logic [7:0] v, output logic [7:0] r);
        @(negedge clk) sel = 1'b1;
        shift16(c, v, 1'b0, -1, r);
        @(negedge clk) sel = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset outputs
        check("R9 rdata reset", {7'b0, rdata}, 8'h00);
        check("R9 irq reset", {7'b0, irq_clr}, 8'h00);

        // R3 R9 sweep of the preset image
        for (int i = 0; i < 32; i++) begin
            ram_model[i] = 8'(i * 29) ^ 8'h5A;
            frame(8'(i), 8'h00, got);
            check("R3 R9 ram preset read", got, ram_model[i]);
        end

        // R4 status and control
        frame(8'h30, 8'h00, got); check("R4 status", got, 8'h90);
        frame(8'h31, 8'h00, got); check("R4 control", got, 8'h00);

        // R6 R2 write sweep, then read back
        for (int i = 0; i < 32; i++) begin
            ram_model[i] = 8'((i * 7 + 3)) ^ 8'hC3;
            frame(8'h80 + 8'(i), ram_model[i], got);
        end
        for (int i = 0; i < 32; i++) begin
            frame(8'(i), 8'h00, got);
            check("R6 R2 ram write readback", got, ram_model[i]);
        end

        // R8 aborted write commits nothing and drops rdata_o
        @(negedge clk) sel = 1'b1;
        for (int i = 0; i < 8; i++) send_bit(((8'h85 >> (7 - i)) & 8'h1) != 0, 1'b0);
        for (int i = 0; i < 4; i++) send_bit(~ram_model[5][7-i], 1'b0);
        @(negedge clk) sel = 1'b0;
        @(negedge clk);
        check("R8 rdata low after abort", {7'b0, rdata}, 8'h00);
        frame(8'h05, 8'h00, got);
        check("R8 aborted write ignored", got, ram_model[5]);

        // R10 extra edges in one selection neither shift nor commit
        @(negedge clk) sel = 1'b1;
        shift16(8'h86, 8'h11, 1'b0, -1, got);
        shift16(8'h86, 8'h22, 1'b0, -1, got);
        @(negedge clk) sel = 1'b0;
        repeat (2) @(negedge clk);
        ram_model[6] = 8'h11;
        frame(8'h06, 8'h00, got);
        check("R10 second frame ignored", got, 8'h11);

        // R1 data noise between edges and edges with select low
        @(negedge clk) sel = 1'b1;
        shift16(8'h87, 8'hA6, 1'b1, -1, got);
        @(negedge clk) sel = 1'b0;
        for (int i = 0; i < 8; i++) send_bit(1'b1, 1'b0);
        ram_model[7] = 8'hA6;
        frame(8'h07, 8'h00, got);
        check("R1 noisy write and unselected edges", got, 8'hA6);

        // R5 time fields
        preset(56, 34, 12, 7, 9, 24);
        frame(8'h20, 8'h00, got); check("R5 seconds", got, bcd(56));
        frame(8'h21, 8'h00, got); check("R5 minutes", got, bcd(34));
        frame(8'h22, 8'h00, got); check("R5 hours", got, bcd(12));
        frame(8'h24, 8'h00, got); check("R5 day", got, bcd(7));
        frame(8'h25, 8'h00, got); check("R5 month", got, bcd(9));
        frame(8'h26, 8'h00, got); check("R5 year", got, bcd(24));
        foreach (ram_model[k]) begin end
        for (int c = 8'h27; c <= 8'h2F; c++) begin
            frame(8'(c), 8'h00, got); check("R5 unused time code", got, 8'h00);
        end
        frame(8'h23, 8'h00, got); check("R5 code 0x23", got, 8'h00);
        frame(8'h40, 8'h00, got); check("R5 other command", got, 8'h00);
        frame(8'hFF, 8'h00, got); check("R5 command 0xFF", got, 8'h00);

        // R11 ticks and full rollover
        for (int i = 0; i < 5; i++) pulse_tick();
        frame(8'h20, 8'h00, got); check("R11 seconds after carry", got, bcd(1));
        frame(8'h21, 8'h00, got); check("R11 minute carry", got, bcd(35));
        preset(59, 59, 23, 31, 12, 99);
        pulse_tick();
        frame(8'h20, 8'h00, got); check("R11 rollover sec", got, bcd(0));
        frame(8'h21, 8'h00, got); check("R11 rollover min", got, bcd(0));
        frame(8'h22, 8'h00, got); check("R11 rollover hour", got, bcd(0));
        frame(8'h24, 8'h00, got); check("R11 rollover day", got, bcd(1));
        frame(8'h25, 8'h00, got); check("R11 rollover month", got, bcd(1));
        frame(8'h26, 8'h00, got); check("R11 rollover year", got, bcd(0));

        // R12 tick during the value phase
        preset(19, 0, 0, 1, 1, 0);
        @(negedge clk) sel = 1'b1;
        shift16(8'h20, 8'h00, 1'b0, 3, got);
        @(negedge clk) sel = 1'b0;
        repeat (2) @(negedge clk);
        check("R12 snapshot at first data edge", got, bcd(19));
        frame(8'h20, 8'h00, got); check("R12 tick applied afterwards", got, bcd(20));

        // R7 fault clear
        frame(8'hB1, 8'hFB, got);
        frame(8'h30, 8'h00, got); check("R7 no key no clear", got, 8'h90);
        check("R7 no key no pulse", 8'(irq_cnt), 8'd0);
        frame(8'hB1, 8'h04, got);
        check("R7 one clear pulse", 8'(irq_cnt), 8'd1);
        frame(8'h30, 8'h00, got); check("R7 faults cleared", got, 8'h80);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule